// File: doc/BRIEF.md
# CPU frame injection formatter

This block turns one outgoing frame into the ordered sequence of 32-bit word writes and control strobes that a switch's CPU injection queue accepts. A request supplies the frame length in bytes and a prebuilt internal frame header. The frame bytes then arrive on a byte stream with a valid/ready handshake. The block first emits a start control strobe. It then writes the header words and packs the frame bytes into little-endian words. If the frame has fewer than 15 data words, zero words bring it up to 15. Last come an end control strobe, which carries the count of valid bytes in the final word, and one all-zero placeholder word where the frame check sequence goes.

A request is refused when the queue's ready input is low. A refusal raises a one-cycle busy pulse and counts as a drop. After each frame the block samples the queue's watermark input. If that input is set, the block holds off new requests for a parameterised number of cycles. When that wait ends and the watermark is still set, the block pulses a clear strobe to the queue's transmit watermark counter, and then accepts requests again.

Top module: `cpu_inject_fmt`

## Requirements
- R1: A request (`start` while `req_ready` is high) made while `q_ready` is low produces no word or control write. It drives `busy` high for exactly the next cycle and increments `drops` by one.
- R2: An accepted frame begins with one control write that has `ctl_sof`=1, `ctl_eof`=0 and `ctl_gap`=1. No word write comes before it.
- R3: Right after the start control, the HDR_WORDS header words are written in index order. Word k is taken from `hdr_in[32k+31:32k]`, as captured at acceptance.
- R4: The frame bytes follow, ceil(len/4) words in all. Frame byte 4w+b is placed in bits [8b+7:8b] of data word w, and any unused bytes of the last word are zero.
- R5: When fewer than MIN_WORDS (15) data words have been written, all-zero words are added until the data word count equals MIN_WORDS. Longer frames get no padding.
- R6: After the data comes one control write with `ctl_eof`=1, `ctl_sof`=0 and `ctl_gap`=1. Its `ctl_vld` equals len mod 4, except that it is 0 when len is below 60.
- R7: Exactly one all-zero word is written after the end control. That word is the last write of the frame.
- R8: If `wm_reached` is high in the cycle after the placeholder word, `tx_pause` is high for TIMEOUT_CYC cycles, and `req_ready` is low during all of them.
- R9: In the last pause cycle, `wm_clr` pulses for one cycle only if `wm_reached` is still high. `req_ready` rises in the next cycle.
- R10: On each accepted request `frames_tx` increments by one and `bytes_tx` by the frame length. Refused requests change neither.
- R11: A `start` pulse while `req_ready` is low is ignored. It does not disturb the frame in progress, and it changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame request |
| len_in | input | LEN_W | Frame length in bytes |
| hdr_in | input | 32*HDR_WORDS | Internal frame header, word 0 in the low bits |
| req_ready | output | 1 | Block can take a request |
| busy | output | 1 | One-cycle refusal pulse |
| q_ready | input | 1 | Injection queue ready |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Block takes a byte |
| wr_valid | output | 1 | Word write strobe |
| wr_data | output | 32 | Word to write |
| ctl_valid | output | 1 | Control write strobe |
| ctl_sof | output | 1 | Start of frame flag |
| ctl_eof | output | 1 | End of frame flag |
| ctl_gap | output | 2 | Inter-frame gap size |
| ctl_vld | output | 2 | Valid bytes in the last word |
| wm_reached | input | 1 | Queue watermark reached |
| tx_pause | output | 1 | Upstream transmission paused |
| wm_clr | output | 1 | Watermark counter clear pulse |
| frames_tx | output | CNT_W | Accepted frame count |
| bytes_tx | output | CNT_W | Accepted byte count |
| drops | output | CNT_W | Refused request count |

## Verification
The bench runs lengths at and around the padding edge: 1, 59, 60 and 61 bytes, plus 63 and 64. These catch a design that pads a 60-byte frame or fails to pad a 59-byte one. They also catch one that reports len mod 4 for a short frame, or that leaves stale bytes in a partial last word. A byte stream with bubbles and a request poked in mid-frame expose a packer that loses its byte position, or a request path that is not properly gated. Watermark runs check the pause length and whether the clear pulse appears. In one run the watermark stays set, so a clear is expected. In the other it drops during the wait, so no clear is expected, and a design that clears anyway or never resumes is caught.

// File: rtl/cpu_inject_fmt.sv
module cpu_inject_fmt #(
  parameter int HDR_WORDS   = 4,
  parameter int MIN_WORDS   = 15,
  parameter int LEN_W       = 16,
  parameter int CNT_W       = 32,
  parameter int TIMEOUT_CYC = 5000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [LEN_W-1:0]       len_in,
  input  logic [32*HDR_WORDS-1:0] hdr_in,
  output logic                   req_ready,
  output logic                   busy,
  input  logic                   q_ready,
  input  logic                   in_valid,
  input  logic [7:0]             in_data,
  output logic                   in_ready,
  output logic                   wr_valid,
  output logic [31:0]            wr_data,
  output logic                   ctl_valid,
  output logic                   ctl_sof,
  output logic                   ctl_eof,
  output logic [1:0]             ctl_gap,
  output logic [1:0]             ctl_vld,
  input  logic                   wm_reached,
  output logic                   tx_pause,
  output logic                   wm_clr,
  output logic [CNT_W-1:0]       frames_tx,
  output logic [CNT_W-1:0]       bytes_tx,
  output logic [CNT_W-1:0]       drops
);
  localparam int HIDX_W    = $clog2(HDR_WORDS + 1);
  localparam int TMR_W     = $clog2(TIMEOUT_CYC + 1);
  localparam int MIN_BYTES = 4 * MIN_WORDS;

  typedef enum logic [3:0] {
    S_IDLE, S_SOF, S_HDR, S_GATH, S_DWR, S_PAD, S_EOF, S_CRC, S_WM, S_PAUSE
  } st_t;

  st_t                    state;
  logic [LEN_W-1:0]       len_q, bcnt, wcnt;
  logic [HIDX_W-1:0]      hidx;
  logic [32*HDR_WORDS-1:0] hdr_q;
  logic [31:0]            word_q;
  logic [TMR_W-1:0]       tmr;
  logic                   busy_q;

  wire accept   = start && req_ready && q_ready;
  wire refuse   = start && req_ready && !q_ready;
  wire take     = in_valid && in_ready;
  wire last_b   = (bcnt + 1'b1) == len_q;
  wire tmr_done = tmr == TMR_W'(TIMEOUT_CYC - 1);

  assign req_ready = state == S_IDLE;
  assign in_ready  = state == S_GATH;
  assign busy      = busy_q;
  assign tx_pause  = state == S_PAUSE;
  assign wm_clr    = tx_pause && tmr_done && wm_reached;

  assign wr_valid  = state inside {S_HDR, S_DWR, S_PAD, S_CRC};
  assign wr_data   = (state == S_HDR) ? hdr_q[32*int'(hidx) +: 32] :
                     (state == S_DWR) ? word_q : 32'd0;
  assign ctl_sof   = state == S_SOF;
  assign ctl_eof   = state == S_EOF;
  assign ctl_valid = ctl_sof || ctl_eof;
  assign ctl_gap   = ctl_valid ? 2'd1 : 2'd0;
  assign ctl_vld   = (ctl_eof && len_q >= LEN_W'(MIN_BYTES)) ? len_q[1:0] : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      len_q     <= '0;
      bcnt      <= '0;
      wcnt      <= '0;
      hidx      <= '0;
      hdr_q     <= '0;
      word_q    <= '0;
      tmr       <= '0;
      busy_q    <= 1'b0;
      frames_tx <= '0;
      bytes_tx  <= '0;
      drops     <= '0;
    end else begin
      busy_q <= refuse;
      if (refuse) drops <= drops + 1'b1;
      case (state)
        S_IDLE: if (accept) begin
          state     <= S_SOF;
          len_q     <= len_in;
          hdr_q     <= hdr_in;
          bcnt      <= '0;
          wcnt      <= '0;
          hidx      <= '0;
          word_q    <= '0;
          frames_tx <= frames_tx + 1'b1;
          bytes_tx  <= bytes_tx + CNT_W'(len_in);
        end
        S_SOF: state <= S_HDR;
        S_HDR: begin
          hidx <= hidx + 1'b1;
          if (hidx == HIDX_W'(HDR_WORDS - 1))
            state <= (len_q == '0) ? S_PAD : S_GATH;
        end
        S_GATH: if (take) begin
          word_q[8*int'(bcnt[1:0]) +: 8] <= in_data;
          bcnt <= bcnt + 1'b1;
          if (bcnt[1:0] == 2'd3 || last_b) state <= S_DWR;
        end
        S_DWR: begin
          word_q <= '0;
          wcnt   <= wcnt + 1'b1;
          if (bcnt != len_q)                         state <= S_GATH;
          else if (wcnt + 1'b1 < LEN_W'(MIN_WORDS))  state <= S_PAD;
          else                                       state <= S_EOF;
        end
        S_PAD: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt + 1'b1 >= LEN_W'(MIN_WORDS)) state <= S_EOF;
        end
        S_EOF: state <= S_CRC;
        S_CRC: state <= S_WM;
        S_WM: begin
          tmr   <= '0;
          state <= wm_reached ? S_PAUSE : S_IDLE;
        end
        S_PAUSE: begin
          tmr <= tmr + 1'b1;
          if (tmr_done) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_busy_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $past(start && !q_ready) && !wr_valid && !ctl_valid);
  assert_hdr_after_sof_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_sof |=> wr_valid && !ctl_valid);
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_valid, ctl_valid}));
  assert_pad_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_eof |-> wcnt >= LEN_W'(MIN_WORDS));
  assert_crc_after_eof_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_eof |=> wr_valid && wr_data == 32'd0);
  assert_pause_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pause |-> !req_ready && !in_ready);
  assert_clr_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wm_clr |-> wm_reached && tx_pause ##1 req_ready);
endmodule

// File: tb/cpu_inject_fmt_test.sv
module cpu_inject_fmt_test;
  localparam int H = 4, MINW = 15, LW = 16, CW = 32, TO = 20;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic start = 0, q_ready = 1, wm_in = 0, gap_mode = 0, src_load = 0;
  logic [LW-1:0] flen = 0;
  logic [32*H-1:0] hdr = 0;
  logic req_ready, busy, in_valid, in_ready, wr_valid, ctl_valid, ctl_sof, ctl_eof;
  logic tx_pause, wm_clr;
  logic [7:0] in_data;
  logic [31:0] wr_data;
  logic [1:0] ctl_gap, ctl_vld;
  logic [CW-1:0] frames_tx, bytes_tx, drops;

  cpu_inject_fmt #(.HDR_WORDS(H), .MIN_WORDS(MINW), .LEN_W(LW), .CNT_W(CW), .TIMEOUT_CYC(TO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_in(flen), .hdr_in(hdr),
    .req_ready(req_ready), .busy(busy), .q_ready(q_ready),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wr_valid(wr_valid), .wr_data(wr_data), .ctl_valid(ctl_valid),
    .ctl_sof(ctl_sof), .ctl_eof(ctl_eof), .ctl_gap(ctl_gap), .ctl_vld(ctl_vld),
    .wm_reached(wm_in), .tx_pause(tx_pause), .wm_clr(wm_clr),
    .frames_tx(frames_tx), .bytes_tx(bytes_tx), .drops(drops));

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [7:0] mem [128];
  int src_idx = 0, src_len = 0;

  assign in_valid = (src_idx < src_len) && !(gap_mode && cyc[0]);
  assign in_data  = mem[src_idx & 127];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (src_load) src_idx <= 0;
    else if (in_valid && in_ready) src_idx <= src_idx + 1;
  end

  logic        lg_ctl [64];
  logic [31:0] lg_dat [64];
  int log_n = 0, pause_n = 0, clr_n = 0;

  always @(negedge clk) begin
    if (wr_valid || ctl_valid) begin
      if (log_n < 64) begin
        lg_ctl[log_n] = ctl_valid;
        lg_dat[log_n] = ctl_valid ? {26'd0, ctl_sof, ctl_eof, ctl_gap, ctl_vld} : wr_data;
      end
      log_n = log_n + 1;
    end
    if (tx_pause) pause_n = pause_n + 1;
    if (wm_clr) clr_n = clr_n + 1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic run_frame(input int len, input bit wm, input bit wm_drop, input bit gaps, input bit poke);
    int nw, tot, bad_h, bad_d, bad_p, exp_vld;
    logic [CW-1:0] f0, b0, d0;
    logic [31:0] ew;
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 37 + len + 1);
    for (int k = 0; k < H; k++) hdr[32*k +: 32] = 32'hA5000000 | 32'(k * 16 + len);
    gap_mode = gaps; wm_in = wm;
    f0 = frames_tx; b0 = bytes_tx; d0 = drops;
    src_load = 1; @(negedge clk); src_load = 0; src_len = len;
    log_n = 0; pause_n = 0; clr_n = 0;
    start = 1; flen = LW'(len); @(negedge clk); start = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1; flen = 5; @(negedge clk); start = 0;
    end
    if (wm_drop) begin
      while (!tx_pause) @(negedge clk);
      repeat (3) @(negedge clk);
      wm_in = 0;
    end
    wait_idle();
    wm_in = 0;
    nw = (len + 3) / 4;
    tot = 1 + H + (nw < MINW ? MINW : nw) + 2;
    check(log_n == tot, $sformatf("R7 write count len=%0d", len), log_n, tot);
    if (log_n == tot) begin
      check(lg_ctl[0] && lg_dat[0][5:0] == 6'b100100, "R2 start control", lg_dat[0], 36);
      bad_h = 0;
      for (int k = 0; k < H; k++)
        if (lg_ctl[1+k] || lg_dat[1+k] != hdr[32*k +: 32]) bad_h++;
      check(bad_h == 0, "R3 header words", bad_h, 0);
      bad_d = 0;
      for (int w = 0; w < nw; w++) begin
        for (int b = 0; b < 4; b++) ew[8*b +: 8] = (4*w + b < len) ? mem[4*w + b] : 8'd0;
        if (lg_ctl[1+H+w] || lg_dat[1+H+w] != ew) bad_d++;
      end
      check(bad_d == 0, $sformatf("R4 data packing len=%0d", len), bad_d, 0);
      bad_p = 0;
      for (int w = nw; w < MINW; w++) if (lg_ctl[1+H+w] || lg_dat[1+H+w] != 0) bad_p++;
      check(bad_p == 0, $sformatf("R5 padding len=%0d", len), bad_p, 0);
      exp_vld = (len < 60) ? 0 : len % 4;
      check(lg_ctl[tot-2] && lg_dat[tot-2][5:0] == 6'(8'b010100 | exp_vld),
            $sformatf("R6 end control len=%0d", len), lg_dat[tot-2], 20 + exp_vld);
      check(!lg_ctl[tot-1] && lg_dat[tot-1] == 0, "R7 placeholder word", lg_dat[tot-1], 0);
    end
    check(frames_tx == f0 + 1, "R10 frames_tx", frames_tx, f0 + 1);
    check(bytes_tx == b0 + CW'(len), "R10 bytes_tx", bytes_tx, b0 + CW'(len));
    check(drops == d0, "R11 drops untouched", drops, d0);
    check(pause_n == (wm ? TO : 0), "R8 pause length", pause_n, wm ? TO : 0);
    check(clr_n == ((wm && !wm_drop) ? 1 : 0), "R9 clear pulse", clr_n, (wm && !wm_drop) ? 1 : 0);
  endtask

  task automatic refused_request();
    logic [CW-1:0] f0, d0;
    f0 = frames_tx; d0 = drops;
    q_ready = 0; log_n = 0;
    start = 1; flen = 40; @(negedge clk); start = 0;
    check(busy == 1'b1, "R1 busy pulse", busy, 1);
    @(negedge clk);
    check(busy == 1'b0, "R1 busy one cycle", busy, 0);
    repeat (5) @(negedge clk);
    check(log_n == 0, "R1 no writes", log_n, 0);
    check(drops == d0 + 1, "R1 drops", drops, d0 + 1);
    check(frames_tx == f0, "R10 frames unchanged on refuse", frames_tx, f0);
    check(req_ready == 1'b1, "R1 still ready", req_ready, 1);
    q_ready = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !wr_valid && !ctl_valid && !tx_pause && !busy, "reset outputs", 0, 1);
    check(frames_tx == 0 && bytes_tx == 0 && drops == 0, "R10 reset counters", frames_tx, 0);
    run_frame(1, 0, 0, 0, 0);
    run_frame(59, 0, 0, 1, 0);
    run_frame(60, 0, 0, 0, 0);
    run_frame(61, 0, 0, 1, 1);
    run_frame(63, 1, 0, 0, 0);
    run_frame(64, 1, 1, 0, 0);
    refused_request();
    run_frame(7, 0, 0, 0, 1);
    summary();
  end
endmodule